// File: doc/BRIEF.md
# Serial Character Receiver with Multidrop Address Filter

This block turns an asynchronous serial input into characters and holds them in a small receive queue. It times the line with a 16-bit divisor and a choice of 4 or 16 samples per bit, and it can flip the polarity of the line before it is sampled. A 2-bit format code selects one of four framings: 8 data bits with no parity, 8 with even parity, 8 with odd parity, or 9 data bits with no parity. A further select chooses one or two stop bits. Each character is stored as 9 data bits together with its own framing and parity error flags.

A consumer reads the entry at the head of the queue from the read outputs and removes it with a one-cycle pop strobe. The interrupt output asserts when the queue holds at least one character, at least half its depth, or at least three quarters of its depth, as chosen by a 2-bit selector. In multidrop systems the address filter can be switched on. While it is on, characters are thrown away until a 9-bit character arrives whose top bit is set and whose low byte equals the programmed station value. That character and everything after it are kept until the filter is switched off.

The frame engine is a state machine with these states:

- `ST_IDLE` waits for a low level and moves to `ST_START`.
- `ST_START` returns to `ST_IDLE` if the line is high at mid-bit (a false start). Otherwise it moves to `ST_DATA`.
- `ST_DATA` moves to `ST_PARITY` after the last data bit in the parity formats, and to `ST_STOP1` otherwise.
- `ST_PARITY` moves to `ST_STOP1`.
- `ST_STOP1` moves to `ST_STOP2` when two stop bits are selected, and to `ST_DONE` otherwise.
- `ST_STOP2` moves to `ST_DONE`.
- `ST_DONE` hands the character over and returns to `ST_IDLE` if the line is high, or goes to `ST_HOLD` if it is low.
- `ST_HOLD` waits for the line to go high and then returns to `ST_IDLE`.

Top module: `serial_rx_addrfilt`

## Requirements
- R1: After reset the queue is empty, `stat_avail`, `stat_overrun` and `rx_irq` are 0, and `stat_idle` is 1.
- R2: Data bits are taken least significant first at mid-bit. Format code 0 gives 8 data bits and no parity, 1 gives 8 bits plus even parity, 2 gives 8 bits plus odd parity, and 3 gives 9 data bits and no parity. In the 8-bit formats the stored bit 8 is 0.
- R3: In format 1 the data bits and the parity bit together must hold an even number of ones, and in format 2 an odd number. A mismatch sets `rd_perr` for that entry only.
- R4: With `cfg_two_stop` at 0 one stop bit is checked, and with it at 1 two are checked. A stop bit sampled low sets `rd_ferr` for that entry only.
- R5: With `cfg_invert` at 1 the line is complemented before sampling, so that idle is low and a start bit is high.
- R6: One bit lasts (`cfg_div`+1)×16 clock cycles when `cfg_fast` is 0, and (`cfg_div`+1)×4 cycles when it is 1.
- R7: A low pulse that has ended before mid-bit of the start bit is ignored: no character is stored and the receiver returns to idle.
- R8: The queue holds 8 entries and is read in arrival order. The head entry is always present on `rd_data`/`rd_ferr`/`rd_perr` while `stat_avail` is 1, and a `pop` removes it.
- R9: A character that completes while the queue is full is dropped, the stored entries stay unchanged, and `stat_overrun` goes to 1 and stays at 1 until reset.
- R10: `rx_irq` is `count >= 1` for `cfg_irq_sel` 0 or 3, `count >= 4` for 1, and `count >= 6` for 2.
- R11: While `cfg_addr_en` is 1 and no match has yet occurred, a character is dropped unless its bit 8 is 1 and its bits 7:0 equal `cfg_addr`. The matching character is stored and filtering stops. Clearing `cfg_addr_en` re-arms the filter for the next time it is enabled.
- R12: `stat_idle` is 0 while a frame is in progress (from the start bit to the final stop bit) and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_fmt | input | 2 | Format code (0 8N, 1 8E, 2 8O, 3 9N) |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| cfg_invert | input | 1 | 1 complements the input line |
| cfg_fast | input | 1 | 1 selects 4 samples per bit, 0 selects 16 |
| cfg_div | input | 16 | Baud divisor; sample period is cfg_div+1 cycles |
| cfg_irq_sel | input | 2 | Interrupt fill-level select |
| cfg_addr_en | input | 1 | Enables address filtering |
| cfg_addr | input | 8 | Station address to match |
| rx_line | input | 1 | Serial input |
| pop | input | 1 | Removes the head entry |
| rd_data | output | 9 | Head entry character |
| rd_ferr | output | 1 | Head entry framing error |
| rd_perr | output | 1 | Head entry parity error |
| stat_avail | output | 1 | Queue not empty |
| stat_overrun | output | 1 | Sticky overrun flag |
| stat_idle | output | 1 | No frame in progress |
| rx_irq | output | 1 | Fill-level interrupt |

## Verification
The bench uses the default parameters: an 8-entry queue and a 16-bit divisor. With them the half-full and three-quarter thresholds fall at 4 and 6 entries, and an overrun is reached with nine frames. Small divisor values (1, 2 and 4) keep each frame a few hundred cycles long. This lets every format, both stop counts, both sample rates, inversion, false starts and the address filter all run in one bench. A queue model in the bench is compared with the status, head entry and interrupt on every quiet clock.

// File: rtl/srx_pkg.sv
package srx_pkg;
    localparam int unsigned OS_SLOW = 16;
    localparam int unsigned OS_FAST = 4;
    localparam int unsigned CHAR_W  = 9;

    localparam logic [1:0] FMT_8N = 2'd0;
    localparam logic [1:0] FMT_8E = 2'd1;
    localparam logic [1:0] FMT_8O = 2'd2;
    localparam logic [1:0] FMT_9N = 2'd3;

    typedef enum logic [2:0] {
        ST_IDLE, ST_START, ST_DATA, ST_PARITY,
        ST_STOP1, ST_STOP2, ST_DONE, ST_HOLD
    } rx_state_e;

    typedef struct packed {
        logic              perr;
        logic              ferr;
        logic [CHAR_W-1:0] data;
    } rx_entry_t;
endpackage

// File: rtl/srx_line_in.sv
module srx_line_in #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_raw,
    input  logic invert,
    output logic line_s
);
    logic [SYNC_STAGES-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_raw};
    end

    assign line_s = sync_q[SYNC_STAGES-1] ^ invert;
endmodule

// File: rtl/srx_baud.sv
module srx_baud #(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt_q <= '0;
        else if (!run)         cnt_q <= '0;
        else if (cnt_q == div) cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
    end

    assign tick = run && (cnt_q == div);

    // R6: with a nonzero divisor two sample ticks are never adjacent
    a_r6_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div != '0 && $stable(div)) |=> !tick);
endmodule

// File: rtl/srx_framer.sv
module srx_framer
    import srx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_s,
    input  logic       tick,
    input  logic [1:0] fmt,
    input  logic       two_stop,
    input  logic       fast,
    output logic       run,
    output logic       idle,
    output logic       chr_valid,
    output rx_entry_t  chr
);
    localparam int unsigned SC_W = $clog2(OS_SLOW);
    localparam logic [SC_W-1:0] HALF_SLOW = SC_W'(OS_SLOW / 2 - 1);
    localparam logic [SC_W-1:0] HALF_FAST = SC_W'(OS_FAST / 2 - 1);
    localparam logic [SC_W-1:0] FULL_SLOW = SC_W'(OS_SLOW - 1);
    localparam logic [SC_W-1:0] FULL_FAST = SC_W'(OS_FAST - 1);
    localparam int unsigned BI_W = $clog2(CHAR_W);

    rx_state_e         state_q, state_n;
    logic [SC_W-1:0]   sc_q;
    logic [BI_W-1:0]   bidx_q;
    logic [CHAR_W-1:0] shreg_q;
    logic              ferr_q, perr_q;

    logic [SC_W-1:0] half_m1, full_m1;
    logic [BI_W-1:0] last_bit;
    logic            has_par, at_mid, at_end, exp_par;

    assign half_m1  = fast ? HALF_FAST : HALF_SLOW;
    assign full_m1  = fast ? FULL_FAST : FULL_SLOW;
    assign last_bit = (fmt == FMT_9N) ? BI_W'(CHAR_W - 1) : BI_W'(CHAR_W - 2);
    assign has_par  = (fmt == FMT_8E) || (fmt == FMT_8O);
    assign at_mid   = tick && (sc_q == half_m1);
    assign at_end   = tick && (sc_q == full_m1);
    assign exp_par  = (fmt == FMT_8O) ? ~(^shreg_q[7:0]) : (^shreg_q[7:0]);

    // next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:   if (!line_s) state_n = ST_START;
            ST_START:  if (at_mid) state_n = line_s ? ST_IDLE : ST_DATA;
            ST_DATA:   if (at_end && bidx_q == last_bit)
                           state_n = has_par ? ST_PARITY : ST_STOP1;
            ST_PARITY: if (at_end) state_n = ST_STOP1;
            ST_STOP1:  if (at_end) state_n = two_stop ? ST_STOP2 : ST_DONE;
            ST_STOP2:  if (at_end) state_n = ST_DONE;
            ST_DONE:   state_n = line_s ? ST_IDLE : ST_HOLD;
            ST_HOLD:   if (line_s) state_n = ST_IDLE;
            default:   state_n = ST_IDLE;
        endcase
    end

    // state register and frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sc_q    <= '0;
            bidx_q  <= '0;
            shreg_q <= '0;
            ferr_q  <= 1'b0;
            perr_q  <= 1'b0;
        end else begin
            state_q <= state_n;
            if (state_n != state_q || at_end) sc_q <= '0;
            else if (tick)                    sc_q <= sc_q + 1'b1;
            unique case (state_q)
                ST_IDLE: begin
                    bidx_q  <= '0;
                    shreg_q <= '0;
                    ferr_q  <= 1'b0;
                    perr_q  <= 1'b0;
                end
                ST_DATA: if (at_end) begin
                    shreg_q[bidx_q] <= line_s;
                    bidx_q          <= bidx_q + 1'b1;
                end
                ST_PARITY: if (at_end) perr_q <= (line_s != exp_par);
                ST_STOP1, ST_STOP2: if (at_end) ferr_q <= ferr_q | ~line_s;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        run       = 1'b0;
        idle      = 1'b1;
        chr_valid = 1'b0;
        unique case (state_q)
            ST_START, ST_DATA, ST_PARITY, ST_STOP1, ST_STOP2: begin
                run  = 1'b1;
                idle = 1'b0;
            end
            ST_DONE: chr_valid = 1'b1;
            default: ;
        endcase
        chr.data = shreg_q;
        chr.ferr = ferr_q;
        chr.perr = perr_q;
    end

    // R7: a start that is high again at mid-bit goes back to idle
    a_r7_false_start: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_START && at_mid && line_s) |=> (state_q == ST_IDLE));
    // R4: a character is only handed over right after a stop bit
    a_r4_done_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE) |-> ($past(state_q) == ST_STOP1 || $past(state_q) == ST_STOP2));
    // R2: in 8-bit formats the ninth bit of a character stays clear
    a_r2_ninth_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_valid && fmt != FMT_9N) |-> !chr.data[CHAR_W-1]);
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo
    import srx_pkg::*;
#(
    parameter int unsigned DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  rx_entry_t                    wr_entry,
    input  logic                         pop,
    output rx_entry_t                    head,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty
);
    localparam int unsigned PTR_W = $clog2(DEPTH);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    rx_entry_t        mem_q [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             push_ok, pop_ok;

    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign count   = cnt_q;
    assign head    = mem_q[rd_ptr_q];

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[wr_ptr_q] <= wr_entry;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
        end else begin
            if (push_ok) wr_ptr_q <= wr_ptr_q + 1'b1;
            if (pop_ok)  rd_ptr_q <= rd_ptr_q + 1'b1;
            unique case ({push_ok, pop_ok})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: ;
            endcase
        end
    end

    // R9: a push into a full queue without a pop leaves the count alone
    a_r9_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (count == $past(count)));
    // R8: a pop alone removes exactly one entry
    a_r8_pop_step: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !empty && !push) |=> (count == $past(count) - 1'b1));
endmodule

// File: rtl/serial_rx_addrfilt.sv
module serial_rx_addrfilt
    import srx_pkg::*;
#(
    parameter int unsigned DIV_W      = 16,
    parameter int unsigned FIFO_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_fmt,
    input  logic              cfg_two_stop,
    input  logic              cfg_invert,
    input  logic              cfg_fast,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [1:0]        cfg_irq_sel,
    input  logic              cfg_addr_en,
    input  logic [7:0]        cfg_addr,
    input  logic              rx_line,
    input  logic              pop,
    output logic [CHAR_W-1:0] rd_data,
    output logic              rd_ferr,
    output logic              rd_perr,
    output logic              stat_avail,
    output logic              stat_overrun,
    output logic              stat_idle,
    output logic              rx_irq
);
    localparam int unsigned CNT_W   = $clog2(FIFO_DEPTH + 1);
    localparam int unsigned THR_HALF = FIFO_DEPTH / 2;
    localparam int unsigned THR_3Q   = (3 * FIFO_DEPTH) / 4;

    logic             line_s, run, tick, chr_valid, full, empty;
    logic             matched_q, ovr_q, accept, push;
    rx_entry_t        chr, head;
    logic [CNT_W-1:0] count, thr;

    srx_line_in u_line (
        .clk(clk), .rst_n(rst_n), .line_raw(rx_line),
        .invert(cfg_invert), .line_s(line_s)
    );

    srx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .run(run), .div(cfg_div), .tick(tick)
    );

    srx_framer u_framer (
        .clk(clk), .rst_n(rst_n), .line_s(line_s), .tick(tick),
        .fmt(cfg_fmt), .two_stop(cfg_two_stop), .fast(cfg_fast),
        .run(run), .idle(stat_idle), .chr_valid(chr_valid), .chr(chr)
    );

    srx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .wr_entry(chr), .pop(pop),
        .head(head), .count(count), .full(full), .empty(empty)
    );

    // address filter: pass everything unless armed and not yet matched
    assign accept = !cfg_addr_en || matched_q ||
                    (chr.data[CHAR_W-1] && chr.data[7:0] == cfg_addr);
    assign push   = chr_valid && accept;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            matched_q <= 1'b0;
            ovr_q     <= 1'b0;
        end else begin
            if (!cfg_addr_en)           matched_q <= 1'b0;
            else if (push)              matched_q <= 1'b1;
            if (push && full)           ovr_q     <= 1'b1;
        end
    end

    always_comb begin
        unique case (cfg_irq_sel)
            2'd1:    thr = CNT_W'(THR_HALF);
            2'd2:    thr = CNT_W'(THR_3Q);
            default: thr = CNT_W'(1);
        endcase
    end

    assign rx_irq       = (count >= thr);
    assign stat_avail   = !empty;
    assign stat_overrun = ovr_q;
    assign rd_data      = head.data;
    assign rd_ferr      = head.ferr;
    assign rd_perr      = head.perr;

    // R9: overrun is sticky
    a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        stat_overrun |=> stat_overrun);
    // R10: lowest threshold tracks data availability
    a_r10_irq_any: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_irq_sel == 2'd0 || cfg_irq_sel == 2'd3) |-> (rx_irq == stat_avail));
    // R11: while armed and unmatched, nothing enters the queue except a matching address
    a_r11_filter: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr_en && !matched_q && chr_valid && !chr.data[CHAR_W-1]) |=> (count == $past(count) - CNT_W'($past(pop && !empty))));
endmodule

// File: tb/serial_rx_addrfilt_tb_top.sv
module serial_rx_addrfilt_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_fmt = 2'd0;
    logic        cfg_two_stop = 1'b0;
    logic        cfg_invert = 1'b0;
    logic        cfg_fast = 1'b0;
    logic [15:0] cfg_div = 16'd1;
    logic [1:0]  cfg_irq_sel = 2'd0;
    logic        cfg_addr_en = 1'b0;
    logic [7:0]  cfg_addr = 8'h00;
    logic        rx_line = 1'b1;
    logic        pop = 1'b0;
    logic [8:0]  rd_data;
    logic        rd_ferr, rd_perr, stat_avail, stat_overrun, stat_idle, rx_irq;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;
    bit model_sync = 1'b0;
    bit m_ovr = 1'b0;
    bit m_matched = 1'b0;
    logic [10:0] mq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_rx_addrfilt dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_fmt(cfg_fmt), .cfg_two_stop(cfg_two_stop),
        .cfg_invert(cfg_invert), .cfg_fast(cfg_fast), .cfg_div(cfg_div),
        .cfg_irq_sel(cfg_irq_sel), .cfg_addr_en(cfg_addr_en), .cfg_addr(cfg_addr),
        .rx_line(rx_line), .pop(pop), .rd_data(rd_data), .rd_ferr(rd_ferr),
        .rd_perr(rd_perr), .stat_avail(stat_avail), .stat_overrun(stat_overrun),
        .stat_idle(stat_idle), .rx_irq(rx_irq)
    );

    function automatic void chk(input bit ok, input string tag,
                                input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endfunction

    function automatic bit exp_irq();
        int thr;
        thr = (cfg_irq_sel == 2'd1) ? DEPTH/2 : (cfg_irq_sel == 2'd2) ? (3*DEPTH)/4 : 1;
        return mq.size() >= thr;
    endfunction

    // per-clock comparison against the queue model
    always @(negedge clk) begin
        if (model_sync && rst_n) begin
            chk(stat_avail == (mq.size() > 0), "R8 avail", 32'(stat_avail), 32'(mq.size() > 0));
            if (mq.size() > 0)
                chk({rd_perr, rd_ferr, rd_data} == mq[0], "R8 head",
                    32'({rd_perr, rd_ferr, rd_data}), 32'(mq[0]));
            chk(stat_overrun == m_ovr, "R9 overrun", 32'(stat_overrun), 32'(m_ovr));
            chk(rx_irq == exp_irq(), "R10 irq", 32'(rx_irq), 32'(exp_irq()));
            chk(stat_idle == 1'b1, "R12 idle when quiet", 32'(stat_idle), 32'd1);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles == WATCHDOG) begin
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected<%0d", cycles, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic drive(input logic b);
        rx_line = b ^ cfg_invert;
    endtask

    task automatic do_reset();
        model_sync = 1'b0;
        rst_n = 1'b0;
        mq.delete();
        m_ovr = 1'b0;
        m_matched = 1'b0;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
        chk(stat_avail == 1'b0, "R1 avail", 32'(stat_avail), 32'd0);
        chk(stat_overrun == 1'b0, "R1 overrun", 32'(stat_overrun), 32'd0);
        chk(rx_irq == 1'b0, "R1 irq", 32'(rx_irq), 32'd0);
        chk(stat_idle == 1'b1, "R1 idle", 32'(stat_idle), 32'd1);
        model_sync = 1'b1;
    endtask

    task automatic send_frame(input logic [8:0] val, input bit bad_par,
                              input bit bad_s1, input bit bad_s2);
        int bc, nb;
        bit par_fmt, p;
        logic [10:0] ent;
        bc = (int'(cfg_div) + 1) * (cfg_fast ? 4 : 16);
        nb = (cfg_fmt == 2'd3) ? 9 : 8;
        par_fmt = (cfg_fmt == 2'd1) || (cfg_fmt == 2'd2);
        model_sync = 1'b0;
        drive(1'b0);
        wait_cyc(bc);
        for (int i = 0; i < nb; i++) begin
            drive(val[i]);
            if (i == 0) begin
                wait_cyc(bc / 2);
                chk(stat_idle == 1'b0, "R12 busy in frame", 32'(stat_idle), 32'd0);
                wait_cyc(bc - bc / 2);
            end else begin
                wait_cyc(bc);
            end
        end
        if (par_fmt) begin
            p = ^val[7:0];
            if (cfg_fmt == 2'd2) p = ~p;
            if (bad_par) p = ~p;
            drive(p);
            wait_cyc(bc);
        end
        drive(~bad_s1);
        wait_cyc(bc);
        if (cfg_two_stop) begin
            drive(~bad_s2);
            wait_cyc(bc);
        end
        drive(1'b1);
        wait_cyc(8);
        ent[8:0] = (cfg_fmt == 2'd3) ? val : {1'b0, val[7:0]};
        ent[9]   = bad_s1 || (cfg_two_stop && bad_s2);
        ent[10]  = par_fmt && bad_par;
        if (!cfg_addr_en || m_matched || (ent[8] && ent[7:0] == cfg_addr)) begin
            if (cfg_addr_en) m_matched = 1'b1;
            if (mq.size() < DEPTH) mq.push_back(ent);
            else m_ovr = 1'b1;
        end
        wait_cyc(1);
        model_sync = 1'b1;
    endtask

    task automatic pop_one();
        pop = 1'b1;
        wait_cyc(1);
        pop = 1'b0;
        if (mq.size() > 0) void'(mq.pop_front());
        wait_cyc(1);
    endtask

    initial begin
        do_reset();

        // R2: 8N, LSB first
        cfg_fmt = 2'd0; cfg_div = 16'd1;
        send_frame(9'h0A5, 0, 0, 0);
        chk(rd_data == 9'h0A5, "R2 8N data", 32'(rd_data), 32'h0A5);
        pop_one();
        send_frame(9'h1FF, 0, 0, 0);
        chk(rd_data == 9'h0FF, "R2 8-bit clears bit 8", 32'(rd_data), 32'h0FF);
        pop_one();

        // R3: even and odd parity, good and bad
        cfg_fmt = 2'd1;
        send_frame(9'h03C, 0, 0, 0);
        send_frame(9'h03D, 1, 0, 0);
        chk(rd_perr == 1'b0, "R3 even good", 32'(rd_perr), 32'd0);
        pop_one();
        chk(rd_perr == 1'b1, "R3 even bad", 32'(rd_perr), 32'd1);
        pop_one();
        cfg_fmt = 2'd2; cfg_div = 16'd2;
        send_frame(9'h081, 0, 0, 0);
        send_frame(9'h07E, 1, 0, 0);
        chk(rd_perr == 1'b0, "R3 odd good", 32'(rd_perr), 32'd0);
        pop_one();
        chk(rd_perr == 1'b1 && rd_data == 9'h07E, "R3 odd bad", 32'({rd_perr, rd_data}), 32'h27E);
        pop_one();

        // R2: 9-bit format
        cfg_fmt = 2'd3; cfg_div = 16'd1;
        send_frame(9'h1C3, 0, 0, 0);
        chk(rd_data == 9'h1C3, "R2 9N data", 32'(rd_data), 32'h1C3);
        pop_one();

        // R4: stop bits
        cfg_fmt = 2'd0;
        send_frame(9'h055, 0, 1, 0);
        chk(rd_ferr == 1'b1, "R4 one stop low", 32'(rd_ferr), 32'd1);
        pop_one();
        cfg_two_stop = 1'b1;
        send_frame(9'h066, 0, 0, 1);
        send_frame(9'h077, 0, 0, 0);
        chk(rd_ferr == 1'b1, "R4 second stop low", 32'(rd_ferr), 32'd1);
        pop_one();
        chk(rd_ferr == 1'b0 && rd_data == 9'h077, "R4 two stops good", 32'({rd_ferr, rd_data}), 32'h077);
        pop_one();
        cfg_two_stop = 1'b0;

        // R5: inverted line
        model_sync = 1'b0;
        cfg_invert = 1'b1;
        rx_line = 1'b0;
        wait_cyc(80);
        model_sync = 1'b1;
        send_frame(9'h0C9, 0, 0, 0);
        chk(rd_data == 9'h0C9, "R5 inverted data", 32'(rd_data), 32'h0C9);
        pop_one();
        model_sync = 1'b0;
        cfg_invert = 1'b0;
        rx_line = 1'b1;
        wait_cyc(80);
        model_sync = 1'b1;

        // R6: fast sampling
        cfg_fast = 1'b1; cfg_div = 16'd4;
        send_frame(9'h0B4, 0, 0, 0);
        chk(rd_data == 9'h0B4, "R6 fast rate", 32'(rd_data), 32'h0B4);
        pop_one();
        cfg_fast = 1'b0; cfg_div = 16'd2;
        send_frame(9'h01E, 0, 0, 0);
        chk(rd_data == 9'h01E, "R6 slow rate div2", 32'(rd_data), 32'h01E);
        pop_one();

        // R7: glitch shorter than half a bit
        cfg_div = 16'd1;
        model_sync = 1'b0;
        rx_line = 1'b0;
        wait_cyc(6);
        rx_line = 1'b1;
        wait_cyc(64);
        chk(stat_avail == 1'b0, "R7 no char from glitch", 32'(stat_avail), 32'd0);
        chk(stat_idle == 1'b1, "R7 back to idle", 32'(stat_idle), 32'd1);
        model_sync = 1'b1;

        // R8, R10, R9: fill, thresholds, overrun
        for (int k = 0; k < DEPTH; k++) begin
            send_frame(9'(8'h10 + k), 0, 0, 0);
            if (k == 2) begin
                cfg_irq_sel = 2'd1; wait_cyc(1);
                chk(rx_irq == 1'b0, "R10 half below", 32'(rx_irq), 32'd0);
            end
            if (k == 3) chk(rx_irq == 1'b1, "R10 half reached", 32'(rx_irq), 32'd1);
            if (k == 4) begin
                cfg_irq_sel = 2'd2; wait_cyc(1);
                chk(rx_irq == 1'b0, "R10 3q below", 32'(rx_irq), 32'd0);
            end
            if (k == 5) chk(rx_irq == 1'b1, "R10 3q reached", 32'(rx_irq), 32'd1);
        end
        cfg_irq_sel = 2'd3; wait_cyc(1);
        chk(rx_irq == 1'b1, "R10 sel3 any", 32'(rx_irq), 32'd1);
        send_frame(9'h0EE, 0, 0, 0);
        chk(stat_overrun == 1'b1, "R9 overrun set", 32'(stat_overrun), 32'd1);
        for (int k = 0; k < DEPTH; k++) begin
            chk(rd_data == 9'(8'h10 + k), "R8 order", 32'(rd_data), 32'(8'h10 + k));
            pop_one();
        end
        chk(stat_avail == 1'b0 && stat_overrun == 1'b1, "R9 drop and sticky",
            32'({stat_avail, stat_overrun}), 32'h1);
        cfg_irq_sel = 2'd0;

        // R11: address filter
        do_reset();
        cfg_fmt = 2'd3; cfg_addr = 8'h5A; cfg_addr_en = 1'b1;
        send_frame(9'h033, 0, 0, 0);
        send_frame(9'h15B, 0, 0, 0);
        send_frame(9'h05A, 0, 0, 0);
        chk(stat_avail == 1'b0, "R11 unmatched dropped", 32'(stat_avail), 32'd0);
        send_frame(9'h15A, 0, 0, 0);
        send_frame(9'h044, 0, 0, 0);
        chk(rd_data == 9'h15A, "R11 address kept", 32'(rd_data), 32'h15A);
        pop_one();
        chk(rd_data == 9'h044, "R11 data after match", 32'(rd_data), 32'h044);
        pop_one();
        cfg_addr_en = 1'b0; wait_cyc(2);
        m_matched = 1'b0;
        cfg_addr_en = 1'b1; wait_cyc(2);
        send_frame(9'h022, 0, 0, 0);
        chk(stat_avail == 1'b0, "R11 re-armed", 32'(stat_avail), 32'd0);
        cfg_addr_en = 1'b0; wait_cyc(2);

        wait_cyc(4);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule